// File: doc/BRIEF.md
# Responder Resolution Unit

This block sits beside an array of processing elements (PEs) that each keep one responder flag, set when that PE matched the latest parallel search. It holds the responder vector in a register. From that register it derives two things without waiting a cycle. The first is a global flag that tells the instruction-stream controller that at least one PE responded. The second is, for each PE, a flag that says some PE with a lower index also responded. A PE whose own bit is set and whose lower-index flag is clear is the first responder.

Three selection commands act on the stored vector. Each command picks the first responder and reports it as an index and as a one-hot vector. Step then removes the picked PE from the set, so repeated steps visit every responder in ascending index order. Find leaves the set as it was. Resolve-first keeps only the picked PE. The PE array writes a fresh vector through a load port. The lower-index network is built either as a ripple chain or as a logarithmic tree, chosen by a parameter.

Top module: `rsp_resolve`

## Requirements
- R1: `before_o[i]` equals the OR of `rsp_o[j]` for all j < i, so `before_o[0]` is always 0. It follows the stored vector in the same cycle.
- R2: `any_o` is 1 exactly when at least one bit of `rsp_o` is 1.
- R3: A command is `cmd_valid_i` high, `load_i` low and `cmd_op_i` not 00. One cycle after a command, `sel_onehot_o` has a single 1 at the lowest set index of the vector held when the command was taken. `sel_idx_o` gives that index in binary and `sel_valid_o` is 1.
- R4: Step (`cmd_op_i` = 01) clears only the picked bit of the vector. Repeating step until `any_o` drops picks every initially set PE once, in ascending index order.
- R5: Find (`cmd_op_i` = 10) leaves the vector unchanged.
- R6: Resolve-first (`cmd_op_i` = 11) leaves only the picked bit set.
- R7: A command given while the vector is all zeros gives `sel_valid_o` = 0 and `sel_onehot_o` = 0, and leaves the vector all zeros.
- R8: `load_i` high writes `load_vec_i` into the vector at the next edge and clears `sel_valid_o` and `sel_onehot_o`. If a command arrives in the same cycle, the load wins and the command is dropped.
- R9: `cmd_valid_i` with `cmd_op_i` = 00 changes neither the vector nor any selection output.
- R10: After reset the vector and all selection outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write `load_vec_i` into the responder vector |
| load_vec_i | input | PE_COUNT | New responder vector from the PE array |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 2 | 00 none, 01 step, 10 find, 11 resolve-first |
| rsp_o | output | PE_COUNT | Stored responder vector |
| before_o | output | PE_COUNT | Per-PE flag: a lower-index PE responds |
| any_o | output | 1 | At least one responder |
| sel_valid_o | output | 1 | The last command found a responder |
| sel_idx_o | output | IDX_W | Index of the picked PE |
| sel_onehot_o | output | PE_COUNT | One-hot select vector of the picked PE |

## Verification
Some properties hold on every cycle, and the assertions check them continuously. These are the prefix relation on every bit, the match between the any flag and the vector, the one-hot form of the select vector and its agreement with the index, and the effect of each command and of a load on the vector one cycle later. Other behaviour only shows up over a sequence of commands, so only the bench's scenarios can show it. The step loop must end after exactly as many picks as there were set bits, visiting them in ascending order. Find must keep returning the same PE, and resolve-first must leave a vector that find then reports as a single responder.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   typedef enum logic [1:0] {
      RSP_OP_NONE    = 2'b00,
      RSP_OP_STEP    = 2'b01,
      RSP_OP_FIND    = 2'b10,
      RSP_OP_RESOLVE = 2'b11
   } rsp_op_e;
endpackage

// File: rtl/rsp_prefix.sv
// Exclusive prefix-OR over the responder vector, ripple or log-depth.
module rsp_prefix #(
   parameter int unsigned PE_COUNT   = 4,
   parameter bit          LOG_PREFIX = 1'b0,
   localparam int unsigned LVLS      = $clog2(PE_COUNT)
) (
   input  logic [PE_COUNT-1:0] req_i,
   output logic [PE_COUNT-1:0] before_o,
   output logic                any_o
);
   logic [PE_COUNT-1:0] incl;

   if (LOG_PREFIX) begin : g_tree
      logic [PE_COUNT-1:0] lvl [0:LVLS];
      assign lvl[0] = req_i;
      for (genvar s = 0; s < LVLS; s++) begin : g_stage
         for (genvar i = 0; i < PE_COUNT; i++) begin : g_bit
            if (i >= (1 << s)) begin : g_or
               assign lvl[s+1][i] = lvl[s][i] | lvl[s][i-(1<<s)];
            end else begin : g_pass
               assign lvl[s+1][i] = lvl[s][i];
            end
         end
      end
      assign incl = lvl[LVLS];
   end else begin : g_ripple
      assign incl[0] = req_i[0];
      for (genvar i = 1; i < PE_COUNT; i++) begin : g_bit
         assign incl[i] = incl[i-1] | req_i[i];
      end
   end

   assign before_o = {incl[PE_COUNT-2:0], 1'b0};
   assign any_o    = incl[PE_COUNT-1];
endmodule

// File: rtl/rsp_pick.sv
// First-responder one-hot and binary index.
module rsp_pick #(
   parameter int unsigned PE_COUNT = 4,
   parameter int unsigned IDX_W    = 2
) (
   input  logic [PE_COUNT-1:0] req_i,
   input  logic [PE_COUNT-1:0] before_i,
   output logic [PE_COUNT-1:0] onehot_o,
   output logic [IDX_W-1:0]    idx_o
);
   assign onehot_o = req_i & ~before_i;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < PE_COUNT; i++) begin
         if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/rsp_update.sv
// Next responder vector for each selection operation.
module rsp_update
   import rsp_pkg::*;
#(
   parameter int unsigned PE_COUNT = 4
) (
   input  rsp_op_e             op_i,
   input  logic [PE_COUNT-1:0] cur_i,
   input  logic [PE_COUNT-1:0] onehot_i,
   output logic [PE_COUNT-1:0] nxt_o
);
   always_comb begin
      unique case (op_i)
         RSP_OP_STEP:    nxt_o = cur_i & ~onehot_i;
         RSP_OP_RESOLVE: nxt_o = onehot_i;
         default:        nxt_o = cur_i;
      endcase
   end
endmodule

// File: rtl/rsp_resolve.sv
module rsp_resolve
   import rsp_pkg::*;
#(
   parameter int unsigned PE_COUNT   = 4,
   parameter bit          LOG_PREFIX = 1'b0,
   localparam int unsigned IDX_W     = $clog2(PE_COUNT)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                load_i,
   input  logic [PE_COUNT-1:0] load_vec_i,
   input  logic                cmd_valid_i,
   input  logic [1:0]          cmd_op_i,
   output logic [PE_COUNT-1:0] rsp_o,
   output logic [PE_COUNT-1:0] before_o,
   output logic                any_o,
   output logic                sel_valid_o,
   output logic [IDX_W-1:0]    sel_idx_o,
   output logic [PE_COUNT-1:0] sel_onehot_o
);
   if (PE_COUNT < 2) begin : g_bad_count
      $error("rsp_resolve: PE_COUNT must be at least 2");
   end

   logic [PE_COUNT-1:0] rsp_q, sel_onehot_q, onehot, nxt;
   logic [IDX_W-1:0]    sel_idx_q, idx;
   logic                sel_valid_q;
   rsp_op_e             op;

   assign op = rsp_op_e'(cmd_op_i);

   rsp_prefix #(.PE_COUNT(PE_COUNT), .LOG_PREFIX(LOG_PREFIX)) prefix_i (
      .req_i(rsp_q), .before_o(before_o), .any_o(any_o)
   );

   rsp_pick #(.PE_COUNT(PE_COUNT), .IDX_W(IDX_W)) pick_i (
      .req_i(rsp_q), .before_i(before_o), .onehot_o(onehot), .idx_o(idx)
   );

   rsp_update #(.PE_COUNT(PE_COUNT)) update_i (
      .op_i(op), .cur_i(rsp_q), .onehot_i(onehot), .nxt_o(nxt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_q        <= '0;
         sel_onehot_q <= '0;
         sel_idx_q    <= '0;
         sel_valid_q  <= 1'b0;
      end else if (load_i) begin
         rsp_q        <= load_vec_i;
         sel_onehot_q <= '0;
         sel_idx_q    <= '0;
         sel_valid_q  <= 1'b0;
      end else if (cmd_valid_i && op != RSP_OP_NONE) begin
         rsp_q        <= nxt;
         sel_onehot_q <= onehot;
         sel_idx_q    <= idx;
         sel_valid_q  <= any_o;
      end
   end

   assign rsp_o        = rsp_q;
   assign sel_onehot_o = sel_onehot_q;
   assign sel_idx_o    = sel_idx_q;
   assign sel_valid_o  = sel_valid_q;
endmodule

// File: rtl/rsp_resolve_chk.sv
module rsp_resolve_chk #(
   parameter int unsigned PE_COUNT   = 4,
   localparam int unsigned IDX_W     = $clog2(PE_COUNT)
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                load_i,
   input logic [PE_COUNT-1:0] load_vec_i,
   input logic                cmd_valid_i,
   input logic [1:0]          cmd_op_i,
   input logic [PE_COUNT-1:0] rsp_o,
   input logic [PE_COUNT-1:0] before_o,
   input logic                any_o,
   input logic                sel_valid_o,
   input logic [IDX_W-1:0]    sel_idx_o,
   input logic [PE_COUNT-1:0] sel_onehot_o
);
   logic is_cmd;
   assign is_cmd = cmd_valid_i && !load_i && cmd_op_i != 2'b00;

   for (genvar i = 0; i < PE_COUNT; i++) begin : g_pre
      localparam logic [PE_COUNT-1:0] LOW = PE_COUNT'((64'd1 << i) - 64'd1);
      p_before_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         before_o[i] == |(rsp_o & LOW));
   end

   p_any_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_o == (rsp_o != '0));

   p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sel_onehot_o));

   p_idx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o |-> (sel_onehot_o[sel_idx_o] && $countones(sel_onehot_o) == 1));

   p_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_cmd |=> (((sel_onehot_o - PE_COUNT'(1)) & $past(rsp_o)) == '0)
                 && ((sel_onehot_o & $past(rsp_o)) == sel_onehot_o)
                 && (sel_valid_o == ($past(rsp_o) != '0)));

   p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_cmd && cmd_op_i == 2'b01) |=> rsp_o == ($past(rsp_o) & ~sel_onehot_o));

   p_find_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_cmd && cmd_op_i == 2'b10) |=> $stable(rsp_o));

   p_resolve_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_cmd && cmd_op_i == 2'b11) |=> rsp_o == sel_onehot_o);

   p_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_cmd && rsp_o == '0) |=> (!sel_valid_o && sel_onehot_o == '0 && rsp_o == '0));

   p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (rsp_o == $past(load_vec_i) && !sel_valid_o && sel_onehot_o == '0));

   p_nop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && !load_i && cmd_op_i == 2'b00) |=>
         ($stable(rsp_o) && $stable(sel_onehot_o) && $stable(sel_valid_o)));
endmodule

bind rsp_resolve rsp_resolve_chk #(.PE_COUNT(PE_COUNT)) chk_i (.*);

// File: tb/rsp_resolve_tb_top.sv
`timescale 1ns/1ps
module rsp_resolve_tb_top;
   localparam int N  = 8;
   localparam int IW = $clog2(N);

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          load_i = 1'b0;
   logic [N-1:0]  load_vec_i = '0;
   logic          cmd_valid_i = 1'b0;
   logic [1:0]    cmd_op_i = 2'b00;
   logic [N-1:0]  rsp_o, before_o, sel_onehot_o;
   logic          any_o, sel_valid_o;
   logic [IW-1:0] sel_idx_o;

   int checks = 0;
   int failures = 0;

   always #2.5 clk_i = ~clk_i;

   rsp_resolve #(.PE_COUNT(N), .LOG_PREFIX(1'b1)) dut_i (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic [N-1:0] exp_before(input logic [N-1:0] v);
      logic [N-1:0] r = '0;
      logic acc = 1'b0;
      for (int i = 0; i < N; i++) begin
         r[i] = acc;
         acc  = acc | v[i];
      end
      return r;
   endfunction

   task automatic do_load(input logic [N-1:0] v);
      load_i = 1'b1; load_vec_i = v;
      @(negedge clk_i);
      load_i = 1'b0;
   endtask

   task automatic do_cmd(input logic [1:0] op);
      cmd_valid_i = 1'b1; cmd_op_i = op;
      @(negedge clk_i);
      cmd_valid_i = 1'b0; cmd_op_i = 2'b00;
   endtask

   task automatic t_reset;
      chk(rsp_o == '0 && sel_onehot_o == '0 && !sel_valid_o && !any_o, "R10", rsp_o, 0);
   endtask

   task automatic t_prefix;
      logic [N-1:0] pats [4] = '{8'h01, 8'h80, 8'h5A, 8'h00};
      foreach (pats[k]) begin
         do_load(pats[k]);
         chk(rsp_o == pats[k], "R8", rsp_o, pats[k]);
         chk(before_o == exp_before(pats[k]), "R1", before_o, exp_before(pats[k]));
         chk(any_o == (pats[k] != '0), "R2", any_o, pats[k] != '0);
      end
   endtask

   task automatic t_step_walk(input logic [N-1:0] v);
      logic [N-1:0] model = v;
      int count = 0;
      int prev = -1;
      do_load(v);
      while (any_o && count <= N) begin
         int e = lowest(model);
         do_cmd(2'b01);
         chk(sel_valid_o && int'(sel_idx_o) == e, "R3", sel_idx_o, e);
         chk(sel_onehot_o == (N'(1) << e), "R3", sel_onehot_o, N'(1) << e);
         chk(e > prev, "R4", e, prev + 1);
         model[e] = 1'b0;
         chk(rsp_o == model, "R4", rsp_o, model);
         prev = e;
         count++;
      end
      chk(count == $countones(v), "R4", count, $countones(v));
   endtask

   task automatic t_find;
      do_load(8'b0110_1000);
      repeat (2) begin
         do_cmd(2'b10);
         chk(sel_valid_o && sel_idx_o == 3, "R3", sel_idx_o, 3);
         chk(rsp_o == 8'b0110_1000, "R5", rsp_o, 8'b0110_1000);
      end
   endtask

   task automatic t_resolve;
      do_load(8'b1100_0100);
      do_cmd(2'b11);
      chk(sel_idx_o == 2 && sel_valid_o, "R3", sel_idx_o, 2);
      chk(rsp_o == 8'b0000_0100, "R6", rsp_o, 8'b0000_0100);
      do_cmd(2'b10);
      chk(rsp_o == 8'b0000_0100 && sel_idx_o == 2, "R6", rsp_o, 8'b0000_0100);
   endtask

   task automatic t_empty;
      do_load('0);
      for (int op = 1; op < 4; op++) begin
         do_cmd(2'(op));
         chk(!sel_valid_o && sel_onehot_o == '0, "R7", sel_onehot_o, 0);
         chk(rsp_o == '0 && !any_o, "R7", rsp_o, 0);
      end
   endtask

   task automatic t_nop;
      do_load(8'b0011_0000);
      do_cmd(2'b10);
      do_cmd(2'b00);
      chk(rsp_o == 8'b0011_0000, "R9", rsp_o, 8'b0011_0000);
      chk(sel_valid_o && sel_onehot_o == 8'b0001_0000, "R9", sel_onehot_o, 8'b0001_0000);
   endtask

   task automatic t_load_wins;
      do_load(8'b0000_0011);
      do_cmd(2'b10);
      load_i = 1'b1; load_vec_i = 8'b1010_0000;
      cmd_valid_i = 1'b1; cmd_op_i = 2'b11;
      @(negedge clk_i);
      load_i = 1'b0; cmd_valid_i = 1'b0; cmd_op_i = 2'b00;
      chk(rsp_o == 8'b1010_0000, "R8", rsp_o, 8'b1010_0000);
      chk(!sel_valid_o && sel_onehot_o == '0, "R8", sel_onehot_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      t_reset();
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_prefix();
      t_step_walk(8'b1011_0101);
      t_step_walk(8'hFF);
      t_step_walk(8'h80);
      t_find();
      t_resolve();
      t_empty();
      t_nop();
      t_load_wins();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule